// File: doc/BRIEF.md
# Auto-Negotiation Priority Resolver

This block picks the operating mode of an Ethernet link once auto-negotiation has finished. It takes two 16-bit advertisement words. One is what the local station offered. The other is what the link partner reported. The block then chooses the best mode that both sides support.

When the negotiation-complete strobe `an_done` is high on a rising clock edge, the block registers four results:
- a speed flag,
- a duplex flag,
- a one-hot mode code,
- a no-common-mode flag.

These results stay unchanged until the next strobe or reset. Link pulse signalling and next-page exchange are handled elsewhere.

All pins are plain control and status signals. There is no back-pressure: the strobe is a single-cycle qualifier, and the results are ordinary registered levels that a consumer may read at any time.

Top module: `anr_resolver`

## Requirements
- R1: In both words the ability bits sit at these positions: bit 9 is 100BASE-T4, bit 8 is 100BASE-TX full duplex, bit 7 is 100BASE-TX, bit 6 is 10BASE-T full duplex and bit 5 is 10BASE-T. A mode is a candidate only when its bit is set in both the local and the partner word.
- R2: Among the candidates, the chosen mode is the highest in this ranking, from highest to lowest: 100TX full duplex, T4, 100TX half duplex, 10T full duplex, 10T half duplex.
- R3: `mode_oh` is one-hot at all times. Its bits mean: bit 4 is 100TX full duplex, bit 3 is T4, bit 2 is 100TX half duplex, bit 1 is 10T full duplex and bit 0 is 10T half duplex.
- R4: `speed_100` is 1 exactly when the mode is one of the three 100 Mb/s modes. `full_duplex` is 1 exactly when the mode is 100TX full duplex or 10T full duplex.
- R5: The partner selector field (bits 4:0) must equal 00001. Any other value gives `no_common`=1, `speed_100`=0, `full_duplex`=0 and `mode_oh`=00001.
- R6: If no ability bit is common to both words, the outputs take the same default as in R5, with `no_common`=1. When a common mode exists, `no_common`=0.
- R7: The outputs change only at a rising edge where `an_done` is 1. At every other edge they hold their values, whatever the inputs do.
- R8: Bits 15:10 of both words have no effect on the result. This covers next page (bit 15), acknowledge (bit 14), remote fault (bit 13) and the reserved bits. The local selector field also has no effect.
- R9: While `rst_n` is low, the outputs are `speed_100`=0, `full_duplex`=0, `mode_oh`=00001 and `no_common`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| an_done | input | 1 | Negotiation-complete strobe; loads the result |
| local_adv | input | 16 | Local advertisement word |
| partner_adv | input | 16 | Link-partner ability word |
| speed_100 | output | 1 | 1 = 100 Mb/s mode resolved |
| full_duplex | output | 1 | 1 = full-duplex mode resolved |
| mode_oh | output | 5 | One-hot resolved mode code |
| no_common | output | 1 | 1 = bad partner selector or no shared mode |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a 5-bit selector whose valid value is 1, and the ability field starting at bit 5.

With only five ability bits per word, every pairing of local and partner abilities can be tried: all 1024 combinations, each compared against a ranking computed in the bench. This covers every priority tie and every empty intersection.

All 32 partner selector values are also swept. Extra runs flip the upper bits and the local selector at random, and change inputs between strobes, to show those inputs have no effect.

// File: rtl/anr_pkg.sv
package anr_pkg;
  localparam int NUM_MODES = 5;
  typedef logic [NUM_MODES-1:0] mode_oh_t;
  // one-hot bit positions, ordered by rank (highest bit = best)
  localparam int M_TXFD = 4;
  localparam int M_T4   = 3;
  localparam int M_TXHD = 2;
  localparam int M_10FD = 1;
  localparam int M_10HD = 0;
  localparam mode_oh_t MODE_FALLBACK = mode_oh_t'(1 << M_10HD);
endpackage

// File: rtl/anr_sel_check.sv
module anr_sel_check #(
  parameter int SEL_W  = 5,
  parameter int SEL_OK = 1
) (
  input  logic [SEL_W-1:0] sel,
  output logic             ok
);
  localparam logic [SEL_W-1:0] OK_VAL = SEL_W'(SEL_OK);
  always_comb ok = (sel == OK_VAL);
endmodule

// File: rtl/anr_prio_pick.sv
module anr_prio_pick #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] pick,
  output logic         any
);
  for (genvar i = 0; i < N; i++) begin : g_lvl
    if (i == N-1) begin : g_top
      assign pick[i] = req[i];
    end else begin : g_low
      assign pick[i] = req[i] & ~(|req[N-1:i+1]);
    end
  end
  assign any = |req;

  always_comb begin
    assert_pick_single_R2: assert ($onehot0(pick));
  end
endmodule

// File: rtl/anr_result_reg.sv
module anr_result_reg
  import anr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  mode_oh_t nxt_mode,
  input  logic     nxt_speed,
  input  logic     nxt_duplex,
  input  logic     nxt_none,
  output mode_oh_t mode,
  output logic     speed,
  output logic     duplex,
  output logic     none
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= MODE_FALLBACK;
      speed  <= 1'b0;
      duplex <= 1'b0;
      none   <= 1'b1;
    end else if (load) begin
      mode   <= nxt_mode;
      speed  <= nxt_speed;
      duplex <= nxt_duplex;
      none   <= nxt_none;
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(mode) && $stable(speed) && $stable(duplex) && $stable(none)));
endmodule

// File: rtl/anr_resolver.sv
module anr_resolver
  import anr_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int SEL_W    = 5,
  parameter int SEL_OK   = 1,
  parameter int ABIL_LSB = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              an_done,
  input  logic [WORD_W-1:0] local_adv,
  input  logic [WORD_W-1:0] partner_adv,
  output logic              speed_100,
  output logic              full_duplex,
  output logic [4:0]        mode_oh,
  output logic              no_common
);
  localparam int ABIL_MSB = ABIL_LSB + NUM_MODES - 1;
  localparam logic [SEL_W-1:0] SEL_GOOD = SEL_W'(SEL_OK);

  // field order inside the ability slice: [4]=T4 [3]=TXFD [2]=TX [1]=10FD [0]=10
  logic [NUM_MODES-1:0] shared;
  mode_oh_t             ranked;
  mode_oh_t             picked;
  logic                 any_shared;
  logic                 sel_good;
  logic                 resolved;
  mode_oh_t             nxt_mode;
  logic                 nxt_speed, nxt_duplex;
  mode_oh_t             mode_q;

  always_comb begin
    shared = local_adv[ABIL_MSB:ABIL_LSB] & partner_adv[ABIL_MSB:ABIL_LSB];
    ranked[M_TXFD] = shared[3];
    ranked[M_T4]   = shared[4];
    ranked[M_TXHD] = shared[2];
    ranked[M_10FD] = shared[1];
    ranked[M_10HD] = shared[0];
  end

  anr_sel_check #(.SEL_W(SEL_W), .SEL_OK(SEL_OK)) u_sel (
    .sel (partner_adv[SEL_W-1:0]),
    .ok  (sel_good)
  );

  anr_prio_pick #(.N(NUM_MODES)) u_pick (
    .req  (ranked),
    .pick (picked),
    .any  (any_shared)
  );

  always_comb begin
    resolved   = sel_good & any_shared;
    nxt_mode   = resolved ? picked : MODE_FALLBACK;
    nxt_speed  = nxt_mode[M_TXFD] | nxt_mode[M_T4] | nxt_mode[M_TXHD];
    nxt_duplex = nxt_mode[M_TXFD] | nxt_mode[M_10FD];
  end

  anr_result_reg u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (an_done),
    .nxt_mode   (nxt_mode),
    .nxt_speed  (nxt_speed),
    .nxt_duplex (nxt_duplex),
    .nxt_none   (~resolved),
    .mode       (mode_q),
    .speed      (speed_100),
    .duplex     (full_duplex),
    .none       (no_common)
  );
  assign mode_oh = mode_q;

  assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_oh) == 1);
  assert_speed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    speed_100 == (mode_oh[M_TXFD] | mode_oh[M_T4] | mode_oh[M_TXHD]));
  assert_duplex_R4: assert property (@(posedge clk) disable iff (!rst_n)
    full_duplex == (mode_oh[M_TXFD] | mode_oh[M_10FD]));
  assert_badsel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (an_done && partner_adv[SEL_W-1:0] != SEL_GOOD) |=> no_common);
  assert_fallback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    no_common |-> (mode_oh == MODE_FALLBACK && !speed_100 && !full_duplex));
endmodule

// File: tb/sim_anr_resolver.sv
module sim_anr_resolver;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        an_done = 1'b0;
  logic [15:0] local_adv = '0;
  logic [15:0] partner_adv = '0;
  logic        speed_100, full_duplex, no_common;
  logic [4:0]  mode_oh;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  anr_resolver u0 (
    .clk(clk), .rst_n(rst_n), .an_done(an_done),
    .local_adv(local_adv), .partner_adv(partner_adv),
    .speed_100(speed_100), .full_duplex(full_duplex),
    .mode_oh(mode_oh), .no_common(no_common)
  );

  // expected result packed as {none, speed, duplex, mode[4:0]}
  function automatic logic [7:0] model(input logic [15:0] l, input logic [15:0] p);
    logic [15:0] c;
    c = l & p;
    if (p[4:0] != 5'd1) return {1'b1, 1'b0, 1'b0, 5'b00001};
    if (c[8]) return {1'b0, 1'b1, 1'b1, 5'b10000};
    if (c[9]) return {1'b0, 1'b1, 1'b0, 5'b01000};
    if (c[7]) return {1'b0, 1'b1, 1'b0, 5'b00100};
    if (c[6]) return {1'b0, 1'b0, 1'b1, 5'b00010};
    if (c[5]) return {1'b0, 1'b0, 1'b0, 5'b00001};
    return {1'b1, 1'b0, 1'b0, 5'b00001};
  endfunction

  task automatic check(input logic [7:0] exp, input string req);
    logic [7:0] act;
    act = {no_common, speed_100, full_duplex, mode_oh};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b (local=%h partner=%h)",
               req, act, exp, local_adv, partner_adv);
    end
  endtask

  task automatic strobe(input logic [15:0] l, input logic [15:0] p);
    @(negedge clk);
    local_adv = l; partner_adv = p; an_done = 1'b1;
    @(negedge clk);
    an_done = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 300000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    check(8'b1_0_0_00001, "R9 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(8'b1_0_0_00001, "R9 after reset release");

    // R1 R2 R3 R4 R6: all ability pairings, valid selectors
    for (int l = 0; l < 32; l++) begin
      for (int p = 0; p < 32; p++) begin
        logic [15:0] lw, pw;
        lw = {6'b0, 5'(l), 5'b00001};
        pw = {6'b0, 5'(p), 5'b00001};
        strobe(lw, pw);
        check(model(lw, pw), "R1/R2/R3/R4/R6 sweep");
      end
    end

    // R5: every partner selector with full abilities on both sides
    for (int s = 0; s < 32; s++) begin
      logic [15:0] pw;
      pw = {6'b0, 5'b11111, 5'(s)};
      strobe(16'h03E1, pw);
      check(model(16'h03E1, pw), "R5 selector");
    end

    // R8: upper bits and local selector randomised
    for (int k = 0; k < 200; k++) begin
      logic [15:0] lw, pw, lc, pc;
      lw = 16'($urandom);
      pw = {6'($urandom), 5'($urandom), 5'b00001};
      lc = {6'b0, lw[9:5], 5'b00001};
      pc = {6'b0, pw[9:5], 5'b00001};
      strobe(lw, pw);
      check(model(lc, pc), "R8 ignored bits");
    end

    // R7: inputs move without strobe, outputs hold
    strobe(16'h0101, 16'h0101);
    held = model(16'h0101, 16'h0101);
    check(held, "R7 load 100TX FD");
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      local_adv = 16'($urandom); partner_adv = 16'($urandom);
      @(negedge clk);
      check(held, "R7 hold without strobe");
    end
    strobe(16'h0021, 16'h0020);
    check(8'b1_0_0_00001, "R5 bad selector after hold");

    // R9: reset mid-run restores defaults
    strobe(16'h0201, 16'h0201);
    check(8'b0_1_0_01000, "R2 T4 alone");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(8'b1_0_0_00001, "R9 reset mid-run");
    rst_n = 1'b1;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule